// File: doc/BRIEF.md
# Pre-adder Multiply-Accumulate Slice

This block is a three-stage pipelined arithmetic slice. Two 25-bit operands can first be summed in a pre-adder. The sum, or the first operand alone when the pre-adder is switched off, is multiplied as a signed value by an 18-bit signed operand. The signed product is sign-extended to 48 bits and handed to a 48-bit ALU. The ALU register also serves as the accumulator.

A two-bit operation code is captured together with the operands on every clock. The ALU can therefore pass the product through, add it to the accumulator, subtract it from the accumulator, or add it to a 48-bit cascade word plus a carry bit from a neighbouring slice. The operation may be different on each cycle. The registered result is driven on a cascade output so that slices can be chained.

A pattern-detect flag is registered alongside the result. It is set when every result bit enabled by a 48-bit mask equals the corresponding pattern bit.

Top module: `macs_slice`

## Requirements
- R1: A synchronous active-high reset clears every pipeline register. One clock edge with reset high leaves `result`, `casc_out` and `pat_match` at zero.
- R2: When `preadd_en` is 1, the multiplicand is the 25-bit two's-complement sum `op_a + op_d`, truncated to 25 bits. For example, 0x0FFFFFF + 1 becomes -2^24.
- R3: When `preadd_en` is 0, `op_a` goes straight to the multiplier and `op_d` has no effect on the result.
- R4: The product is the signed 25 x 18 product of the multiplicand and `op_b`, sign-extended to 48 bits.
- R5: With `op_mode` = 2'b00 the new result equals the product.
- R6: With `op_mode` = 2'b01 the new result equals the previous result plus the product, modulo 2^48. `carry_in` is ignored in this mode.
- R7: With `op_mode` = 2'b10 the new result equals `casc_in + product + carry_in`, modulo 2^48.
- R8: With `op_mode` = 2'b11 the new result equals the previous result minus the product, modulo 2^48.
- R9: Operands, `op_mode`, `preadd_en`, `casc_in` and `carry_in` are sampled on the same edge. Their result is visible after the third rising edge, and consecutive cycles may use different modes.
- R10: `pat_match` is registered with the result. It is 1 exactly when `((result ^ pat_value) & pat_mask) == 0`, where `pat_value` and `pat_mask` are the values present one cycle before the result appears. A mask bit of 0 excludes that bit from the comparison.
- R11: `casc_out` always carries the same value as `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 25 | First pre-adder operand (signed) |
| op_d | input | 25 | Second pre-adder operand (signed) |
| op_b | input | 18 | Multiplier operand (signed) |
| preadd_en | input | 1 | 1 = multiply the sum, 0 = multiply `op_a` |
| op_mode | input | 2 | ALU operation: 00 product, 01 acc+product, 10 cascade+product+carry, 11 acc-product |
| casc_in | input | 48 | Cascade word from the previous slice |
| carry_in | input | 1 | Carry bit added in mode 10 |
| pat_value | input | 48 | Pattern to compare against |
| pat_mask | input | 48 | 1 = bit is compared |
| result | output | 48 | Registered ALU result / accumulator |
| casc_out | output | 48 | Cascade word to the next slice |
| pat_match | output | 1 | Registered pattern-match flag |

## Verification
The bench switches modes on consecutive cycles, so a design that took the mode from the wrong pipeline stage would apply one vector's operation to another vector's product. A pre-adder overflow case checks 25-bit wrap: widening the sum would return +2^24 instead of -2^24. Signed extremes of both multiplier operands and a cascade word at the positive 48-bit limit expose unsigned multiplication and lost sign extension. A carry applied in accumulate mode, a nonzero `op_d` with the pre-adder off, and a mask that hides a differing bit catch leaks from inputs that must be ignored. A reset in the middle of the run catches an accumulator that survives reset.

// File: rtl/macs_pkg.sv
package macs_pkg;
    localparam int A_W   = 25;
    localparam int B_W   = 18;
    localparam int ACC_W = 48;
    localparam int P_W   = A_W + B_W;
    localparam int EXT_W = ACC_W - P_W;

    typedef enum logic [1:0] {
        OP_PROD     = 2'b00,
        OP_ACC_ADD  = 2'b01,
        OP_CASC_ADD = 2'b10,
        OP_ACC_SUB  = 2'b11
    } op_e;

    typedef struct packed {
        logic [A_W-1:0]   a;
        logic [A_W-1:0]   d;
        logic [B_W-1:0]   b;
        logic             pre_en;
        op_e              op;
        logic [ACC_W-1:0] casc;
        logic             cin;
    } in_t;

    typedef struct packed {
        logic [ACC_W-1:0] prod;
        op_e              op;
        logic [ACC_W-1:0] casc;
        logic             cin;
    } prod_t;

    function automatic logic [ACC_W-1:0] sext_prod(input logic [P_W-1:0] p);
        return {{EXT_W{p[P_W-1]}}, p};
    endfunction

    function automatic logic masked_eq(input logic [ACC_W-1:0] v,
                                       input logic [ACC_W-1:0] pat,
                                       input logic [ACC_W-1:0] mask);
        return ((v ^ pat) & mask) == '0;
    endfunction
endpackage

// File: rtl/macs_in_stage.sv
module macs_in_stage
    import macs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  in_t  d_in,
    output in_t  q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d_in;
    end
endmodule

// File: rtl/macs_mult_stage.sv
module macs_mult_stage
    import macs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  in_t   s1,
    output prod_t s2
);
    logic [A_W-1:0]        mcand;
    logic signed [P_W-1:0] mult;

    always_comb begin
        mcand = s1.pre_en ? (s1.a + s1.d) : s1.a;
        mult  = $signed({{B_W{mcand[A_W-1]}}, mcand}) *
                $signed({{A_W{s1.b[B_W-1]}}, s1.b});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.prod <= sext_prod(mult);
            s2.op   <= s1.op;
            s2.casc <= s1.casc;
            s2.cin  <= s1.cin;
        end
    end

    // R1
    prod_reset_chk: assert property (@(posedge clk) rst |=> (s2.prod == '0 && s2.op == OP_PROD));
endmodule

// File: rtl/macs_alu_stage.sv
module macs_alu_stage
    import macs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  prod_t            s2,
    input  logic [ACC_W-1:0] pat,
    input  logic [ACC_W-1:0] mask,
    output logic [ACC_W-1:0] acc,
    output logic             match
);
    logic [ACC_W-1:0] nxt;

    always_comb begin
        unique case (s2.op)
            OP_PROD:     nxt = s2.prod;
            OP_ACC_ADD:  nxt = acc + s2.prod;
            OP_CASC_ADD: nxt = s2.casc + s2.prod + {{(ACC_W-1){1'b0}}, s2.cin};
            OP_ACC_SUB:  nxt = acc - s2.prod;
            default:     nxt = s2.prod;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            match <= 1'b0;
        end else begin
            acc   <= nxt;
            match <= masked_eq(nxt, pat, mask);
        end
    end

    // R1
    acc_reset_chk: assert property (@(posedge clk) rst |=> (acc == '0 && !match));
    // R5
    pass_prod_chk: assert property (@(posedge clk) disable iff (rst)
        s2.op == OP_PROD |=> acc == $past(s2.prod));
    // R6
    acc_add_chk: assert property (@(posedge clk) disable iff (rst)
        s2.op == OP_ACC_ADD |=> acc == $past(acc) + $past(s2.prod));
    // R7
    casc_add_chk: assert property (@(posedge clk) disable iff (rst)
        s2.op == OP_CASC_ADD |=> acc == $past(s2.casc) + $past(s2.prod) + ACC_W'($past(s2.cin)));
    // R8
    acc_sub_chk: assert property (@(posedge clk) disable iff (rst)
        s2.op == OP_ACC_SUB |=> acc == $past(acc) - $past(s2.prod));
    // R10
    match_valid_chk: assert property (@(posedge clk) disable iff (rst)
        match |-> (((acc ^ $past(pat)) & $past(mask)) == '0));
endmodule

// File: rtl/macs_slice.sv
module macs_slice
    import macs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [A_W-1:0]   op_a,
    input  logic [A_W-1:0]   op_d,
    input  logic [B_W-1:0]   op_b,
    input  logic             preadd_en,
    input  logic [1:0]       op_mode,
    input  logic [ACC_W-1:0] casc_in,
    input  logic             carry_in,
    input  logic [ACC_W-1:0] pat_value,
    input  logic [ACC_W-1:0] pat_mask,
    output logic [ACC_W-1:0] result,
    output logic [ACC_W-1:0] casc_out,
    output logic             pat_match
);
    in_t   s0;
    in_t   s1;
    prod_t s2;
    logic [ACC_W-1:0] acc;

    always_comb begin
        s0.a      = op_a;
        s0.d      = op_d;
        s0.b      = op_b;
        s0.pre_en = preadd_en;
        s0.op     = op_e'(op_mode);
        s0.casc   = casc_in;
        s0.cin    = carry_in;
    end

    macs_in_stage u_in (
        .clk (clk),
        .rst (rst),
        .d_in(s0),
        .q   (s1)
    );

    macs_mult_stage u_mult (
        .clk(clk),
        .rst(rst),
        .s1 (s1),
        .s2 (s2)
    );

    macs_alu_stage u_alu (
        .clk  (clk),
        .rst  (rst),
        .s2   (s2),
        .pat  (pat_value),
        .mask (pat_mask),
        .acc  (acc),
        .match(pat_match)
    );

    assign result   = acc;
    assign casc_out = acc;

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        s2.op == op_e'($past(s1.op)));
endmodule

// File: tb/macs_slice_tb.sv
module macs_slice_tb;
    typedef struct packed {
        logic [24:0] a;
        logic [24:0] d;
        logic [17:0] b;
        logic        pe;
        logic [1:0]  m;
        logic [47:0] c;
        logic        ci;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{25'h3,       25'h4,       18'h5,     1'b1, 2'b00, 48'h0,            1'b0},
        '{25'hA,       25'h1FFFFFF, 18'h3FFFE, 1'b1, 2'b01, 48'h0,            1'b0},
        '{25'h64,      25'h7,       18'h3,     1'b0, 2'b01, 48'h0,            1'b1},
        '{25'h0FFFFFF, 25'h1,       18'h1,     1'b1, 2'b00, 48'h0,            1'b0},
        '{25'h2,       25'h2,       18'h1FFFF, 1'b1, 2'b11, 48'h0,            1'b0},
        '{25'h1,       25'h0,       18'h1,     1'b0, 2'b10, 48'h7FFFFFFFFFFF, 1'b1},
        '{25'h1000000, 25'h0,       18'h20000, 1'b0, 2'b00, 48'h0,            1'b0},
        '{25'h123,     25'h55,      18'h0,     1'b1, 2'b00, 48'h0,            1'b0},
        '{25'h5,       25'h9,       18'h5,     1'b0, 2'b11, 48'h0,            1'b1},
        '{25'h3,       25'h3,       18'h3FFFF, 1'b1, 2'b10, 48'h64,           1'b0},
        '{25'h1,       25'h1,       18'h3,     1'b1, 2'b01, 48'h0,            1'b0},
        '{25'h1FFFFFF, 25'h1FFFFFF, 18'h7,     1'b1, 2'b11, 48'hFFFFFFFFFFFF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [24:0] op_a = '0, op_d = '0;
    logic [17:0] op_b = '0;
    logic        preadd_en = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic [47:0] casc_in = '0;
    logic        carry_in = 1'b0;
    logic [47:0] pat_value = '0, pat_mask = '1;
    logic [47:0] result, casc_out;
    logic        pat_match;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;
    logic [47:0] acc_m = '0;

    always #4 clk = ~clk;

    macs_slice u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_d(op_d), .op_b(op_b),
        .preadd_en(preadd_en), .op_mode(op_mode), .casc_in(casc_in),
        .carry_in(carry_in), .pat_value(pat_value), .pat_mask(pat_mask),
        .result(result), .casc_out(casc_out), .pat_match(pat_match)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_a = v.a; op_d = v.d; op_b = v.b; preadd_en = v.pe;
        op_mode = v.m; casc_in = v.c; carry_in = v.ci;
    endtask

    // R2 R3 R4: multiplicand and signed product, computed from the requirements
    function automatic logic [47:0] model_prod(input vec_t v);
        logic signed [24:0] s;
        logic signed [17:0] bb;
        longint p;
        s  = v.pe ? v.a + v.d : v.a;
        bb = v.b;
        p  = longint'(s) * longint'(bb);
        return p[47:0];
    endfunction

    task automatic check_vec(input vec_t v);
        logic [47:0] p, e;
        string t;
        p = model_prod(v);
        case (v.m)
            2'b00: begin e = p;                     t = "R5"; end
            2'b01: begin e = acc_m + p;             t = "R6"; end
            2'b10: begin e = v.c + p + 48'(v.ci);   t = "R7"; end
            default: begin e = acc_m - p;           t = "R8"; end
        endcase
        acc_m = e;
        t = {t, v.pe ? " R2 R4 R9" : " R3 R4 R9"};
        chk(t, result, e);
        chk("R11 cascade", casc_out, e);
        chk("R10 match", 48'(pat_match), 48'(((e ^ pat_value) & pat_mask) == '0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        vec_t z;
        z = '0;
        drive(z);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 result", result, 48'h0);
        chk("R1 casc_out", casc_out, 48'h0);
        chk("R1 match", 48'(pat_match), 48'h0);
        rst = 1'b0;

        // table walk: vector j is checked three edges after it is driven (R9)
        for (int j = 0; j < NV + 3; j++) begin
            @(negedge clk);
            if (j >= 3) check_vec(VEC[j-3]);
            if (j < NV) drive(VEC[j]);
            else        drive(z);
        end

        // R10: masked-out bit differs, still a match
        @(negedge clk);
        pat_value = 48'h4;
        pat_mask  = ~48'h1;
        drive('{25'h1, 25'h0, 18'h5, 1'b0, 2'b00, 48'h0, 1'b0});
        repeat (3) @(negedge clk);
        chk("R5 directed", result, 48'h5);
        chk("R10 masked bit ignored", 48'(pat_match), 48'h1);
        pat_mask = '1;
        @(negedge clk);
        chk("R10 full mask mismatch", 48'(pat_match), 48'h0);

        // R1: reset in mid-run clears the accumulator
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run result", result, 48'h0);
        chk("R1 mid-run casc_out", casc_out, 48'h0);
        rst = 1'b0;
        drive('{25'h2, 25'h0, 18'h3, 1'b0, 2'b01, 48'h0, 1'b1});
        repeat (3) @(negedge clk);
        chk("R6 accumulate after reset", result, 48'h6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule